// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block produces the row strobe, column strobe, write enable and row/column address select that a DRAM needs for one read or write access at a time. A request carries a write flag, a chip-space number and a row and a column address. The block runs an optional idle clock, an optional precharge clock, a row clock and a column phase. It then marks the end of the access with a one-clock done pulse. An external wait input can stretch the column phase when the timing setting allows it.

An 8-bit timing register holds the settings. Reads and writes each have their own column-phase wait count. Other bits enable an idle clock after reads, a fast page mode that keeps a row open across back-to-back accesses, and a mode that holds the row strobe low while the block is idle. The register is written through `cfg_wr`/`cfg_wdata` and read back on `cfg_rdata`. Refresh, bus arbitration and data buffering are handled elsewhere.

Top module: `dram_cycle_seq`

## Requirements
- R1: Register layout: [1:0] write wait count, [3:2] read wait count, [4] idle enable, [5] page mode, [6] row hold mode, [7] reserved. All bits reset to 0. A write takes effect one clock after `cfg_wr`. Bit 7 always reads back 0, whatever value was written.
- R2: An access that does not hit an open row has one row clock. In that clock `ras_n` is 0, `addr_sel` is 0 and `mem_addr` carries the row address.
- R3: The column phase lasts 2 + wait count clocks. The write count applies to writes and the read count to reads. In the column phase `addr_sel` is 1 and `mem_addr` carries the column. `we_n` is 0 throughout the phase for writes and stays 1 for reads. `cas_n` is 0 only in the final clock, and `done` is 1 in that same clock.
- R4: When the wait count of the access is 0 or 1, `ext_wait` has no effect on the access length.
- R5: When the wait count is 2 or 3, `ext_wait` is sampled in the final column clock. Each clock in which it is 1 repeats that clock, with `cas_n` held at 0 and `done` held at 0.
- R6: A request can be accepted in the done clock of a read while idle enable is 1. If that request is a write or targets a different chip space, one idle clock with `cas_n` and `we_n` both 1 comes before it. Any other accepted request gets no idle clock.
- R7: Page mode keeps the row open when the next request is accepted in the done clock. A request to the same row and space then goes straight to the column phase. A request to another row first takes one precharge clock with `ras_n` 1, then the row clock. When no request is accepted in the done clock, the row closes.
- R8: With row hold mode set, `ras_n` stays 0 while idle after an access. A later request to the same row and space goes straight to the column phase. A request to another row takes one precharge clock first.
- R9: With both page mode and row hold mode clear, `ras_n` returns to 1 in the clock after done, and every access has a row clock.
- R10: `req_ready` is 1 in idle and in the done clock, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_wdata | input | 8 | Timing register write value |
| cfg_rdata | output | 8 | Timing register read value |
| req_valid | input | 1 | Access request valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_space | input | SW | Chip-space number of the request |
| req_row | input | AW | Row address |
| req_col | input | AW | Column address |
| req_ready | output | 1 | Request is accepted when valid and ready are both 1 |
| ext_wait | input | 1 | External wait request |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr_sel | output | 1 | 0 = row on `mem_addr`, 1 = column |
| mem_addr | output | AW | Multiplexed DRAM address |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
Counting from the clock edge that accepts a request, `done` is due after (idle clock) + (precharge clock) + (row clock) + (2 + wait count) + (honoured wait clocks) clocks. The bench computes each term from its own model of the open row, the last access and the register, and checks the exact clock in which `done` appears. The row clock, the precharge clock and the idle clock are checked at their own computed offsets. The row strobe level is checked one clock after a done that has no follow-on request. All outputs are sampled 1 ns after the falling edge, after `ext_wait` has been driven for that clock.

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq #(
  parameter int AW = 10,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [SW-1:0] req_space,
  input  logic [AW-1:0] req_row,
  input  logic [AW-1:0] req_col,
  output logic          req_ready,
  input  logic          ext_wait,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          addr_sel,
  output logic [AW-1:0] mem_addr,
  output logic          done
);

  localparam int CW = 3;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_PRE, S_ROW, S_COL} st_t;

  st_t           st, nxt, start_st;
  logic [7:0]    cfg_q;
  logic [CW-1:0] cnt, last_cnt;
  logic          cur_write, row_open, open_nxt;
  logic [SW-1:0] cur_space, open_space, tgt_space;
  logic [AW-1:0] cur_row, cur_col, open_row, tgt_row;
  logic [1:0]    cur_wait;
  logic          idle_en, page_en, hold_en, pg, honour;
  logic          accept, need_gap, open_eff, hit;

  assign idle_en = cfg_q[4];
  assign page_en = cfg_q[5];
  assign hold_en = cfg_q[6];
  assign pg      = page_en | hold_en;
  assign cfg_rdata = cfg_q;

  assign cur_wait = cur_write ? cfg_q[1:0] : cfg_q[3:2];
  assign last_cnt = {1'b0, cur_wait} + 3'd1;
  assign honour   = cur_wait[1];

  assign done      = (st == S_COL) && (cnt == last_cnt) && !(honour && ext_wait);
  assign req_ready = (st == S_IDLE) || done;
  assign accept    = req_valid && req_ready;
  assign need_gap  = done && !cur_write && idle_en &&
                     (req_write || (req_space != cur_space));

  assign tgt_row   = (st == S_GAP) ? cur_row   : req_row;
  assign tgt_space = (st == S_GAP) ? cur_space : req_space;
  assign open_eff  = row_open && ((st != S_COL) || pg);
  assign hit       = open_eff && (tgt_row == open_row) && (tgt_space == open_space);
  assign start_st  = hit ? S_COL : (open_eff ? S_PRE : S_ROW);

  always_comb begin
    nxt      = st;
    open_nxt = row_open;
    case (st)
      S_IDLE: if (accept) begin
        nxt      = start_st;
        open_nxt = (start_st == S_COL);
      end
      S_GAP: begin
        nxt      = start_st;
        open_nxt = (start_st == S_COL);
      end
      S_PRE: nxt = S_ROW;
      S_ROW: begin
        nxt      = S_COL;
        open_nxt = 1'b1;
      end
      S_COL: if (done) begin
        if (!accept) begin
          nxt      = S_IDLE;
          open_nxt = hold_en & row_open;
        end else if (need_gap) begin
          nxt      = S_GAP;
          open_nxt = pg & row_open;
        end else begin
          nxt      = start_st;
          open_nxt = (start_st == S_COL);
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      row_open <= 1'b0;
      cnt      <= '0;
    end else begin
      st       <= nxt;
      row_open <= open_nxt;
      if ((st != S_COL) || done)
        cnt <= '0;
      else if (cnt != last_cnt)
        cnt <= cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (cfg_wr)
      cfg_q <= cfg_wdata & 8'h7F;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write  <= 1'b0;
      cur_space  <= '0;
      cur_row    <= '0;
      cur_col    <= '0;
      open_row   <= '0;
      open_space <= '0;
    end else begin
      if (accept) begin
        cur_write <= req_write;
        cur_space <= req_space;
        cur_row   <= req_row;
        cur_col   <= req_col;
      end
      if (st == S_ROW) begin
        open_row   <= cur_row;
        open_space <= cur_space;
      end
    end
  end

  assign ras_n    = !(row_open || (st == S_ROW));
  assign cas_n    = !((st == S_COL) && (cnt == last_cnt));
  assign we_n     = !((st == S_COL) && cur_write);
  assign addr_sel = (st == S_COL);
  assign mem_addr = (st == S_COL) ? cur_col : cur_row;

endmodule

// File: rtl/dram_cycle_seq_chk.sv
module dram_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       addr_sel,
  input logic       done
);

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0);

  p_cas_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (addr_sel && !ras_n));

  p_done_with_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cas_n);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (addr_sel && !ras_n));

  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid && cfg_rdata[6]) |=> !ras_n);

  p_ras_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid && cfg_rdata[6:5] == 2'b00) |=> ras_n);

  p_ready_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

bind dram_cycle_seq dram_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
  .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr_sel(addr_sel), .done(done)
);

// File: tb/tb_dram_cycle_seq.sv
`timescale 1ns/1ps
module tb_dram_cycle_seq;
  logic       clk = 0, rst_n = 0;
  logic       cfg_wr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic       req_valid = 0, req_write = 0;
  logic [1:0] req_space = 0;
  logic [9:0] req_row = 0, req_col = 0, mem_addr;
  logic       req_ready, ext_wait = 0;
  logic       ras_n, cas_n, we_n, addr_sel, done;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [1:0] m_wr, m_rd;
  bit m_idle, m_page, m_hold;
  bit mo, lw;
  logic [9:0] mrow;
  logic [1:0] msp, lsp;
  bit at_done;

  always #2.5 clk = ~clk;

  dram_cycle_seq #(.AW(10), .SW(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .ext_wait(ext_wait), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr_sel(addr_sel), .mem_addr(mem_addr), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int col_len(input bit w);
    return 2 + int'(w ? m_wr : m_rd);
  endfunction

  function automatic bit honours(input bit w);
    return w ? m_wr[1] : m_rd[1];
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    m_wr = v[1:0]; m_rd = v[3:2]; m_idle = v[4]; m_page = v[5]; m_hold = v[6];
    #1;
    check(cfg_rdata == (v & 8'h7F), "R1 register readback", cfg_rdata, v & 8'h7F);
  endtask

  task automatic idle_step();
    @(negedge clk);
    ext_wait = 0;
    mo = mo & m_hold;
    #1;
    check(ras_n == !mo, m_hold ? "R8 ras level in idle" : "R9 ras level in idle", ras_n, !mo);
    check(req_ready == 1'b1, "R10 ready in idle", req_ready, 1);
  endtask

  task automatic acc(input bit w, input logic [1:0] sp, input logic [9:0] row,
                     input logic [9:0] col, input int hold, input bit chain);
    int g, pre, rw, n, he, L, holdleft, cas_cnt, kk;
    bit hit, got;
    string tag;
    g = (chain && !lw && m_idle && (w || sp != lsp)) ? 1 : 0;
    if (chain) mo = mo & (m_page | m_hold);
    hit = mo && row == mrow && sp == msp;
    pre = (mo && !hit) ? 1 : 0;
    rw = hit ? 0 : 1;
    n = col_len(w);
    he = honours(w) ? hold : 0;
    L = g + pre + rw + n + he;
    if (he > 0) tag = "R5 honoured wait length";
    else if (hold > 0) tag = "R4 ignored wait length";
    else if (g) tag = "R6 idle clock length";
    else if (hit || pre) tag = m_hold ? "R8 open row length" : "R7 page length";
    else tag = "R3 access length";
    check(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1; req_write = w; req_space = sp; req_row = row; req_col = col;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    holdleft = hold; got = 0; cas_cnt = 0; kk = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k > 1) @(negedge clk);
      ext_wait = (cas_n == 1'b0 && holdleft > 0);
      if (ext_wait) holdleft--;
      #1;
      kk = k;
      if (!cas_n) cas_cnt++;
      if (g == 1 && k == 1)
        check(cas_n && we_n, "R6 idle clock strobes", {cas_n, we_n}, 3);
      if (pre == 1 && k == g + 1)
        check(ras_n == 1'b1, m_hold ? "R8 precharge clock" : "R7 precharge clock", ras_n, 1);
      if (!hit && k == g + pre + 1)
        check(ras_n == 0 && addr_sel == 0 && mem_addr == row, "R2 row clock",
              mem_addr, row);
      if (done) begin got = 1; break; end
    end
    check(got && kk == L, tag, kk, L);
    if (got) begin
      check(!cas_n && addr_sel && mem_addr == col && we_n == !w, "R3 final column clock",
            {cas_n, we_n, addr_sel}, {1'b0, !w, 1'b1});
      check(cas_cnt == 1 + he, he > 0 ? "R5 strobe hold count" : "R4 strobe count",
            cas_cnt, 1 + he);
    end
    ext_wait = 0;
    lw = w; lsp = sp;
    if (!hit) begin mo = 1; mrow = row; msp = sp; end
    at_done = 1;
  endtask

  task automatic next_acc(input bit w, input logic [1:0] sp, input logic [9:0] row,
                          input logic [9:0] col, input int hold, input bit chain);
    if (at_done && !chain) idle_step();
    acc(w, sp, row, col, hold, at_done && chain);
  endtask

  task automatic new_cfg(input logic [7:0] v);
    if (at_done) idle_step();
    at_done = 0;
    set_cfg(v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_wr = 0; m_rd = 0; m_idle = 0; m_page = 0; m_hold = 0;
    mo = 0; lw = 1; mrow = 0; msp = 0; lsp = 0; at_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(cfg_rdata == 8'h00, "R1 reset value", cfg_rdata, 0);
    check(ras_n && cas_n && we_n && !done, "R9 reset strobes", {ras_n, cas_n, we_n, done}, 14);
    check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

    set_cfg(8'hFF);
    check(cfg_rdata[7] == 1'b0, "R1 reserved bit", cfg_rdata[7], 0);
    set_cfg(8'h00);

    next_acc(0, 0, 10'h011, 10'h022, 0, 0);
    next_acc(1, 0, 10'h011, 10'h023, 0, 1);
    next_acc(0, 1, 10'h005, 10'h006, 0, 0);

    new_cfg(8'h07);
    next_acc(0, 0, 10'h010, 10'h001, 3, 0);
    next_acc(1, 0, 10'h010, 10'h002, 2, 0);
    next_acc(1, 0, 10'h010, 10'h003, 0, 1);

    new_cfg(8'h10);
    next_acc(0, 0, 10'h020, 10'h004, 0, 0);
    next_acc(1, 0, 10'h020, 10'h005, 0, 1);
    next_acc(0, 0, 10'h020, 10'h006, 0, 0);
    next_acc(0, 1, 10'h020, 10'h007, 0, 1);
    next_acc(0, 1, 10'h020, 10'h008, 0, 1);

    new_cfg(8'h20);
    next_acc(0, 2, 10'h030, 10'h009, 0, 0);
    next_acc(0, 2, 10'h030, 10'h00A, 0, 1);
    next_acc(1, 2, 10'h031, 10'h00B, 0, 1);
    next_acc(0, 2, 10'h031, 10'h00C, 0, 0);

    new_cfg(8'h40);
    next_acc(1, 3, 10'h040, 10'h00D, 0, 0);
    next_acc(0, 3, 10'h040, 10'h00E, 0, 0);
    next_acc(0, 3, 10'h041, 10'h00F, 0, 0);

    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 9) == 0) new_cfg(8'($urandom_range(0, 255)));
      next_acc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 1)),
               10'($urandom_range(0, 2)), 10'($urandom_range(0, 1023)),
               $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end
    if (at_done) idle_step();

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule